// File: doc/BRIEF.md
# PHY Management Register Access Controller

This block lets a host read and write the 16-bit registers of one external Ethernet PHY over the two-wire serial management interface (MDC clock, MDIO data). The host sees a small byte-wide register file. It holds a PHY register number, two bytes of write data, two bytes of read data, a command byte and a status byte. Storing the high write-data byte launches a write. The command byte starts either a single read or a scan. A scan re-reads one PHY register back to back until the host cancels it.

Every access is one 64-bit management frame. The frame is a 32-bit preamble of ones, start `01`, a 2-bit opcode, the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits. MDC is the system clock divided by `2*HALF_DIV`. With the default of 4 on a 50 MHz clock, MDC runs at 6.25 MHz and one access takes 10.24 µs. The status byte shows busy, scan and not-valid flags, plus a sticky error flag. The error flag records requests that were refused because an operation was already running.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every host-readable byte except the write-data bytes reads zero, MDC is low and MDIO is not driven. Host offsets are: 0 register number (bits 4:0), 1 write-data low, 2 write-data high, 3 read-data low, 4 read-data high, 5 command (bit 0 read, bit 1 scan), 6 status (bit 0 busy, bit 1 scan, bit 2 not-valid, bit 3 error).
- R2: A host write to offset 2 launches a PHY write of {offset 2 value, offset 1 value} and sets busy at once. A write to offset 1 alone starts no frame. All 16 bits are sent in every write.
- R3: Each frame on the wire is 32 ones, then 01, then opcode (01 write, 10 read), then PHY address, then register number, then turnaround, then 16 data bits MSB first. Bits are shifted in on MDC rising edges.
- R4: MDC has a period of 2*HALF_DIV clocks and stays low while idle. One access spans 64 MDC periods. Busy clears within a few clocks of the frame's end.
- R5: Writing 1 to command bit 0 while idle starts a single read. The bit reads back 1 during the read and then self-clears. Busy stays set until both read-data bytes hold the PHY value.
- R6: During a read, MDIO is not driven from the first turnaround bit to the end of the frame. The PHY's data is sampled on MDC rising edges.
- R7: Setting command bit 1 while idle sets busy, scan and not-valid together.
- R8: Not-valid clears when the first scan read completes. Later scan reads keep overwriting both read-data bytes at the frame interval, so a changed PHY value appears without host action.
- R9: Clearing command bit 1 during a scan lets the read in progress finish. Busy and scan clear after it, and no further frame starts.
- R10: While busy, any of the following is ignored and sets the error flag, which then stays set until reset: writing offset 0, writing offset 2, setting command bit 0, or setting command bit 1 when no scan is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe for the addressed byte |
| hostAddr | input | 3 | Host byte offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Byte at hostAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen from the pad |

## Verification
Writes are driven with all-zero, all-one, single-edge-bit and mixed data to different register numbers. These patterns separate a swapped byte order, a dropped bit and a bit-order error in the shifter. Single reads return an asymmetric value, which exposes an off-by-one sampling point or a lost turnaround bit. A scan is run while the responder changes its register value, to tell a one-shot read from a continuous one. Cancel and illegal requests are issued at a known MDC bit position during a scan and during a write. This shows whether refused requests leak onto the wire and whether the in-progress read is cut short.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DRIVE_BITS = 46;   // preamble+start+op+phy+reg
  localparam int PRE_BITS   = 32;

  localparam logic [2:0] OFS_REG   = 3'd0;
  localparam logic [2:0] OFS_WRLO  = 3'd1;
  localparam logic [2:0] OFS_WRHI  = 3'd2;
  localparam logic [2:0] OFS_RDLO  = 3'd3;
  localparam logic [2:0] OFS_RDHI  = 3'd4;
  localparam logic [2:0] OFS_CMD   = 3'd5;
  localparam logic [2:0] OFS_STAT  = 3'd6;

  typedef struct packed {
    logic        start;
    logic        isRead;
    logic [4:0]  regNum;
    logic [15:0] wrData;
  } pathCmd_t;
endpackage

// File: rtl/mdio_mgmt_path.sv
module mdio_mgmt_path
  import mdio_mgmt_pkg::*;
#(
  parameter int         HALF_DIV = 4,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rstN,
  input  pathCmd_t    cmd,
  output logic        opDone,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int DIV_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int CNT_W  = $clog2(FRAME_BITS);

  logic                  active;
  logic                  isRd;
  logic [DIV_W-1:0]      divCnt;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftOut;
  logic [15:0]           shiftIn;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    frame = {{PRE_BITS{1'b1}}, 2'b01,
             cmd.isRead ? 2'b10 : 2'b01,
             PHY_ADDR, cmd.regNum,
             cmd.isRead ? 2'b11 : 2'b10,
             cmd.wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      isRd     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shiftOut <= '0;
      shiftIn  <= '0;
      opDone   <= 1'b0;
    end else begin
      opDone <= 1'b0;
      if (cmd.start) begin
        active   <= 1'b1;
        isRd     <= cmd.isRead;
        divCnt   <= '0;
        bitCnt   <= '0;
        shiftOut <= frame;
      end else if (active) begin
        if (isRd && divCnt == DIV_W'(HALF_DIV - 1))
          shiftIn <= {shiftIn[14:0], mdioIn};
        if (divCnt == DIV_W'(PERIOD - 1)) begin
          divCnt   <= '0;
          shiftOut <= {shiftOut[FRAME_BITS-2:0], 1'b0};
          if (bitCnt == CNT_W'(FRAME_BITS - 1)) begin
            active <= 1'b0;
            opDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign mdc     = active && (divCnt >= DIV_W'(HALF_DIV));
  assign mdioOut = shiftOut[FRAME_BITS-1];
  assign mdioOe  = active && (!isRd || bitCnt < CNT_W'(DRIVE_BITS));
  assign rdData  = shiftIn;
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output pathCmd_t    cmd,
  input  logic        opDone,
  input  logic [15:0] rdData
);
  logic [4:0] regNum;
  logic [7:0] wrLo, wrHi, rdLo, rdHi;
  logic readCmd, scanCmd, busy, scanFlag, notValid, errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regNum <= '0; wrLo <= '0; wrHi <= '0; rdLo <= '0; rdHi <= '0;
      readCmd <= 1'b0; scanCmd <= 1'b0; busy <= 1'b0;
      scanFlag <= 1'b0; notValid <= 1'b0; errFlag <= 1'b0;
      cmd <= '0;
    end else begin
      cmd.start <= 1'b0;
      if (opDone) begin
        if (scanFlag) begin
          rdLo <= rdData[7:0]; rdHi <= rdData[15:8];
          notValid <= 1'b0;
          if (scanCmd) cmd.start <= 1'b1;
          else begin busy <= 1'b0; scanFlag <= 1'b0; end
        end else begin
          busy <= 1'b0;
          if (cmd.isRead) begin
            rdLo <= rdData[7:0]; rdHi <= rdData[15:8];
            readCmd <= 1'b0;
          end
        end
      end
      if (hostWe) begin
        unique case (hostAddr)
          OFS_REG:  if (busy) errFlag <= 1'b1; else regNum <= hostWdata[4:0];
          OFS_WRLO: wrLo <= hostWdata;
          OFS_WRHI: if (busy) errFlag <= 1'b1;
                    else begin
                      wrHi <= hostWdata; busy <= 1'b1;
                      cmd.start <= 1'b1; cmd.isRead <= 1'b0;
                      cmd.regNum <= regNum; cmd.wrData <= {hostWdata, wrLo};
                    end
          OFS_CMD:  if (busy) begin
                      if (hostWdata[0] || (hostWdata[1] && !scanFlag)) errFlag <= 1'b1;
                      else scanCmd <= hostWdata[1];
                    end else if (hostWdata[1]) begin
                      scanCmd <= 1'b1; scanFlag <= 1'b1; notValid <= 1'b1;
                      busy <= 1'b1; cmd.start <= 1'b1; cmd.isRead <= 1'b1;
                      cmd.regNum <= regNum;
                    end else begin
                      scanCmd <= 1'b0;
                      if (hostWdata[0]) begin
                        readCmd <= 1'b1; busy <= 1'b1; cmd.start <= 1'b1;
                        cmd.isRead <= 1'b1; cmd.regNum <= regNum;
                      end
                    end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (hostAddr)
      OFS_REG:  hostRdata = {3'b000, regNum};
      OFS_WRLO: hostRdata = wrLo;
      OFS_WRHI: hostRdata = wrHi;
      OFS_RDLO: hostRdata = rdLo;
      OFS_RDHI: hostRdata = rdHi;
      OFS_CMD:  hostRdata = {6'b0, scanCmd, readCmd};
      OFS_STAT: hostRdata = {4'b0, errFlag, notValid, scanFlag, busy};
      default:  hostRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int         HALF_DIV = 4,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWe,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       mdc,
  output logic       mdioOut,
  output logic       mdioOe,
  input  logic       mdioIn
);
  pathCmd_t    pathCmd;
  logic        opDone;
  logic [15:0] rdData;

  mdio_mgmt_regs uCtrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cmd(pathCmd),
    .opDone(opDone), .rdData(rdData)
  );

  mdio_mgmt_path #(.HALF_DIV(HALF_DIV), .PHY_ADDR(PHY_ADDR)) uPath (
    .clk(clk), .rstN(rstN), .cmd(pathCmd), .opDone(opDone),
    .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic scanFlag,
  input logic notValid,
  input logic errFlag,
  input logic opDone,
  input logic mdc,
  input logic mdioOe
);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));
  p_nvalid_in_scan_r7: assert property (@(posedge clk) disable iff (!rstN)
    notValid |-> scanFlag);
  p_scan_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    scanFlag |-> busy);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  p_done_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !scanFlag) |=> !busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk uChk (
  .clk(clk), .rstN(rstN), .busy(uCtrl.busy), .scanFlag(uCtrl.scanFlag),
  .notValid(uCtrl.notValid), .errFlag(uCtrl.errFlag), .opDone(opDone),
  .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;
  localparam logic [4:0] PHY = 5'h12;

  logic clk = 1'b0, rstN = 1'b0, hostWe = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWdata = 8'h00, hostRdata;
  logic mdc, mdioOut, mdioOe, mdioIn;
  logic phyDrive = 1'b1;
  assign mdioIn = phyDrive;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl #(.HALF_DIV(4), .PHY_ADDR(PHY)) i_mdio_mgmt_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY responder and frame monitor
  typedef struct { logic [4:0] r; logic [15:0] d; } wrItem_t;
  wrItem_t expQ[$];
  logic [15:0] phyMem [32];
  logic [63:0] bits = '0;
  logic [4:0] regSel = '0;
  bit rdFrame = 0;
  int rises = 0, frames = 0, writeFrames = 0, readFrames = 0, oeViol = 0;
  realtime riseT1, riseT2;

  task automatic frameDone(input logic [63:0] f);
    wrItem_t e;
    frames++;
    check(f[63:32] == 32'hFFFF_FFFF, "R3 preamble", f[63:32], 32'hFFFF_FFFF);
    check(f[31:30] == 2'b01, "R3 start", f[31:30], 2'b01);
    check(f[27:23] == PHY, "R3 phy address", f[27:23], PHY);
    if (f[29:28] == 2'b01) begin
      writeFrames++;
      phyMem[f[22:18]] = f[15:0];
      if (expQ.size() == 0) check(0, "R2 unexpected write frame", {f[22:18], f[15:0]}, 0);
      else begin
        e = expQ.pop_front();
        check(f[22:18] == e.r, "R3 write register", f[22:18], e.r);
        check(f[15:0] == e.d, "R2 write data 16 bits", f[15:0], e.d);
      end
    end else begin
      check(f[29:28] == 2'b10, "R3 opcode", f[29:28], 2'b10);
      readFrames++;
    end
  endtask

  always @(posedge mdc) begin
    bits = {bits[62:0], mdioOut};
    rises++;
    if (rises == 1) riseT1 = $realtime;
    if (rises == 2) riseT2 = $realtime;
    if (rises == 36) rdFrame = (bits[1:0] == 2'b10);
    if (rises == 46) regSel = bits[4:0];
    if (rdFrame && rises >= 47 && mdioOe) oeViol++;
    if (rises == 64) begin frameDone(bits); rises = 0; rdFrame = 0; end
  end

  always @(negedge mdc) begin
    if (rdFrame && rises + 1 >= 49 && rises + 1 <= 64) phyDrive = phyMem[regSel][63 - rises];
    else if (rdFrame && rises + 1 == 48) phyDrive = 1'b0;
    else phyDrive = 1'b1;
  end

  // host access
  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWe = 1'b0;
  endtask
  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; #1 d = hostRdata;
  endtask
  task automatic waitIdle(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; hostAddr = 3'd6; #1; end
    while (hostRdata[0] && cyc < 5000);
  endtask
  task automatic phyWrite(input logic [4:0] r, input logic [15:0] d);
    wrItem_t e; int c;
    e.r = r; e.d = d; expQ.push_back(e);
    hostWrite(3'd0, {3'b0, r}); hostWrite(3'd1, d[7:0]); hostWrite(3'd2, d[15:8]);
    waitIdle(c);
  endtask

  final begin end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
  end

  initial begin
    logic [7:0] v, lo, hi; int c, f0, w0;
    for (int i = 0; i < 32; i++) phyMem[i] = 16'h0000;
    repeat (3) @(negedge clk); rstN = 1'b1;

    // R1 reset state
    hostRead(3'd6, v); check(v == 8'h00, "R1 status", v, 0);
    hostRead(3'd3, v); check(v == 8'h00, "R1 rd low", v, 0);
    hostRead(3'd4, v); check(v == 8'h00, "R1 rd high", v, 0);
    hostRead(3'd5, v); check(v == 8'h00, "R1 command", v, 0);
    check(!mdc && !mdioOe, "R1 mdio idle", {mdc, mdioOe}, 0);

    // R2 low byte alone starts nothing
    hostWrite(3'd0, 8'd3); hostWrite(3'd1, 8'h5A);
    repeat (600) @(negedge clk);
    check(frames == 0, "R2 low byte no frame", frames, 0);
    hostRead(3'd6, v); check(v[0] == 1'b0, "R2 idle after low byte", v, 0);

    // R2/R4 launch by high byte, busy at once, duration
    expQ.push_back('{5'd3, 16'hC35A});
    hostWrite(3'd2, 8'hC3);
    hostRead(3'd6, v); check(v[0] == 1'b1, "R2 busy on launch", v, 1);
    waitIdle(c);
    check(c >= 508 && c <= 518, "R4 frame length", c, 512);
    check(riseT2 - riseT1 == 160.0, "R4 mdc period", int'(riseT2 - riseT1), 160);
    check(writeFrames == 1, "R2 one write frame", writeFrames, 1);

    // R2/R3 data patterns
    phyWrite(5'd0, 16'h0000);
    phyWrite(5'd31, 16'hFFFF);
    phyWrite(5'd17, 16'h8001);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);

    // R5/R6 single read
    phyMem[7] = 16'hA5C3;
    hostWrite(3'd0, 8'd7); hostWrite(3'd5, 8'h01);
    hostRead(3'd5, v); check(v == 8'h01, "R5 read bit held", v, 1);
    waitIdle(c);
    hostRead(3'd3, lo); hostRead(3'd4, hi);
    check({hi, lo} == 16'hA5C3, "R5 read data", {hi, lo}, 16'hA5C3);
    hostRead(3'd5, v); check(v == 8'h00, "R5 read bit self-clears", v, 0);
    check(oeViol == 0 && readFrames == 1, "R6 mdio released", oeViol, 0);

    // R7/R8 scan
    phyMem[9] = 16'h1234;
    hostWrite(3'd0, 8'd9); hostWrite(3'd5, 8'h02);
    hostRead(3'd6, v); check(v == 8'h07, "R7 scan flags", v, 8'h07);
    c = 0;
    do begin hostRead(3'd6, v); c++; end while (v[2] && c < 2000);
    check(c >= 508 && c <= 518, "R8 not-valid clears after first read", c, 512);
    hostRead(3'd3, lo); hostRead(3'd4, hi);
    check({hi, lo} == 16'h1234, "R8 first scan value", {hi, lo}, 16'h1234);
    phyMem[9] = 16'hBEEF;
    repeat (1100) @(negedge clk);
    hostRead(3'd3, lo); hostRead(3'd4, hi);
    check({hi, lo} == 16'hBEEF, "R8 scan updates", {hi, lo}, 16'hBEEF);
    hostRead(3'd6, v); check(v == 8'h03, "R8 still scanning", v, 8'h03);

    // R10 illegal requests during scan
    w0 = writeFrames;
    hostWrite(3'd0, 8'd4);
    hostRead(3'd0, v); check(v == 8'd9, "R10 register number kept", v, 9);
    hostWrite(3'd1, 8'h11); hostWrite(3'd2, 8'h22);
    hostWrite(3'd5, 8'h03);
    hostRead(3'd6, v); check(v == 8'h0B, "R10 error set, scan on", v, 8'h0B);

    // R9 cancel mid-frame
    wait (rises == 20);
    f0 = frames;
    hostWrite(3'd5, 8'h00);
    hostRead(3'd6, v); check(v[1:0] == 2'b11, "R9 busy until read ends", v, 3);
    waitIdle(c);
    repeat (1100) @(negedge clk);
    check(frames - f0 == 1, "R9 in-progress read finishes only", frames - f0, 1);
    check(writeFrames == w0, "R10 write ignored while busy", writeFrames, w0);
    hostRead(3'd6, v); check(v == 8'h08, "R9 idle, R10 error sticky", v, 8'h08);

    // R10 scan request while a write runs
    expQ.push_back('{5'd9, 16'h0F0F});
    hostWrite(3'd1, 8'h0F); hostWrite(3'd2, 8'h0F);
    f0 = readFrames;
    hostWrite(3'd5, 8'h02);
    waitIdle(c);
    repeat (700) @(negedge clk);
    check(readFrames == f0, "R10 scan refused during write", readFrames, f0);
    hostRead(3'd6, v); check(v == 8'h08, "R10 status after refusal", v, 8'h08);
    check(phyMem[9] == 16'h0F0F, "R2 write after errors", phyMem[9], 16'h0F0F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule